// File: doc/BRIEF.md
# DMA Request and Burst Controller

This block sits between a 16-byte data FIFO and a host DMA channel that is 8 or 16 bits wide. It decides, cycle by cycle, whether to raise the DMA request towards the host. It counts the host's data strobes, which are qualified by the DMA acknowledge, against a loaded byte count. In the device-to-host direction it packs the two oldest FIFO bytes into a bus word. In the host-to-device direction it tells the FIFO how many bytes to accept.

Two configuration bits select the request discipline. In single-transfer mode the request drops after every accepted strobe and is then re-evaluated. In burst mode the request is held back until a full 8-byte burst fits, or is released early when the transfer is ending. The end-of-transfer conditions depend on whether the device acts as initiator or target. A third bit chooses how an odd final byte on a 16-bit bus is handled: either no request is raised for it, or it is sent as a word padded with ones. The block also reports the largest synchronous offset the selected mode allows.

Top module: `dma_burst_ctrl`

## Requirements
- R1: `sync_offset_max` is 15 when `cfg_burst8` is 0, whatever `cfg_ack_hold` is (so the reserved combination `cfg_ack_hold`=1 with `cfg_burst8`=0 behaves as normal mode). It is 7 when `cfg_burst8` is 1.
- R2: With `cfg_burst8` at 0, `dma_req` rises the cycle after the count is non-zero and the FIFO can supply (read) or take (write) one transfer unit. It is low in the cycle after every accepted strobe and is then evaluated again.
- R3: A transfer unit is 2 bytes when `cfg_wide` is 1 and at least 2 bytes remain, otherwise 1 byte. `fifo_pop` (read, `xfer_to_host`=1) or `fifo_push` (write) shows the unit size in the cycle of each accepted strobe and is 0 otherwise. The count drops by the unit.
- R4: With `cfg_burst8` at 1 in write direction, `dma_req` rises only when at least 8 FIFO bytes are free. It then stays high across the strobes of one 8-byte burst and is low in the cycle after the strobe that completes the burst or empties the count.
- R5: With `cfg_burst8` at 1 in read direction as initiator (`role_target`=0), a burst starts once the FIFO holds at least 8 bytes.
- R6: With `cfg_burst8` at 1 in read direction, a drain condition starts a burst for whatever the FIFO holds. The drain conditions are `scsi_cnt_zero` or `phase_change` as initiator, and `target_done` or `attention` as target. The condition is remembered until the next `xfer_load`. As target, FIFO fill alone never starts a burst.
- R7: With `cfg_wide`=1 and `cfg_odd_via_fifo`=1, no request is raised when exactly 1 byte remains.
- R8: With `cfg_wide`=1 and `cfg_odd_via_fifo`=0, the final odd byte is sent on `dma_dout[7:0]` with `dma_dout[15:8]`=8'hFF. `dma_par[1]`=1 and `dma_par[0]` is the odd parity of the low byte. A full word is `fifo_head` unchanged, and each parity bit makes its byte plus parity hold an odd number of ones.
- R9: `cfg_odd_via_fifo` has no effect when `cfg_wide` is 0: a last single byte still raises the request.
- R10: A strobe counts only on its rising edge while `dma_ack` is high. When `cfg_ack_hold` is 0, or in read direction when `cfg_rd_ack_pulse` is 1, `dma_ack` must have been low since the previous accepted strobe. When `cfg_ack_hold` is 1 otherwise, successive strobes under a steady acknowledge all count.
- R11: After reset `dma_req` is low. `xfer_load` loads the count, clears any burst and any remembered drain condition, and forces `dma_req` low for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst8 | input | 1 | Burst mode select |
| cfg_ack_hold | input | 1 | Acknowledge may stay high across strobes |
| cfg_rd_ack_pulse | input | 1 | Read direction needs a fresh acknowledge per strobe |
| cfg_wide | input | 1 | 16-bit host bus |
| cfg_odd_via_fifo | input | 1 | Odd last byte is left to the host, with no request |
| xfer_to_host | input | 1 | 1 = device to host (read), 0 = host to device |
| role_target | input | 1 | 1 = target role, 0 = initiator |
| xfer_load | input | 1 | Load byte count, start a transfer |
| xfer_bytes | input | CNT_W | Byte count to load |
| fifo_level | input | LVL_W | Bytes held in the FIFO |
| fifo_head | input | 16 | Two oldest FIFO bytes, oldest in [7:0] |
| scsi_cnt_zero | input | 1 | Bus-side count reached zero |
| phase_change | input | 1 | Bus phase changed |
| attention | input | 1 | Attention condition active |
| target_done | input | 1 | Target transfer complete |
| dma_ack | input | 1 | DMA acknowledge |
| dma_rd_stb | input | 1 | Host read strobe |
| dma_wr_stb | input | 1 | Host write strobe |
| dma_din | input | 16 | Host write data |
| dma_req | output | 1 | DMA request |
| dma_dout | output | 16 | Read data word |
| dma_par | output | 2 | Odd parity per byte of `dma_dout` |
| fifo_pop | output | 2 | Bytes taken from the FIFO this cycle |
| fifo_push | output | 2 | Bytes written to the FIFO this cycle |
| fifo_wdata | output | 16 | Data for the FIFO, first byte in [7:0] |
| sync_offset_max | output | 4 | Largest synchronous offset allowed |

## Verification
The request logic is driven with counts that are even, odd and single-byte, on both bus widths and in both directions. This shows whether the unit size, the padded final word and the odd-byte suppression each fire only in their own case. In burst mode, the FIFO level is walked just below and then onto the 8-byte threshold, with and without drain events and in both roles. A request that rises one level too early, ignores the role, or forgets a drain condition therefore shows up as a wrong request level. The acknowledge is held steady across two strobes, dropped between them, and left low during a strobe. This separates the held-acknowledge rule from the fresh-acknowledge rule.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE   = 2'b00,
    MODE_BURST    = 2'b01,
    MODE_RESERVED = 2'b10,
    MODE_HELD_ACK = 2'b11
  } dma_mode_e;

  // odd parity bit for one byte
  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

endpackage

// File: rtl/dma_strobe_qual.sv
module dma_strobe_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_to_host,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic ack,
  input  logic cfg_ack_hold,
  input  logic cfg_rd_ack_pulse,
  input  logic cnt_nonzero,
  output logic beat
);

  logic stb, stb_q, stb_q_n;
  logic armed_q, armed_n;
  logic need_rearm;

  always_comb begin
    stb        = xfer_to_host ? rd_stb : wr_stb;
    need_rearm = !cfg_ack_hold || (xfer_to_host && cfg_rd_ack_pulse);
    beat       = stb && !stb_q && ack && (armed_q || !need_rearm) && cnt_nonzero;
    stb_q_n    = stb;
    if (!ack)      armed_n = 1'b1;
    else if (beat) armed_n = 1'b0;
    else           armed_n = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q   <= 1'b0;
      armed_q <= 1'b1;
    end else begin
      stb_q   <= stb_q_n;
      armed_q <= armed_n;
    end
  end

  // R10: under a steady acknowledge, a fresh-acknowledge mode accepts no second strobe
  a_r10_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (need_rearm && $past(need_rearm) && $past(beat) && ack && $past(ack)) |-> !beat);

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl #(
  parameter int CNT_W       = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int BURST_BYTES = 8,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
  localparam int BL_W       = $clog2(BURST_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_burst8,
  input  logic             cfg_wide,
  input  logic             cfg_odd_via_fifo,
  input  logic             xfer_to_host,
  input  logic             role_target,
  input  logic             xfer_load,
  input  logic [CNT_W-1:0] xfer_bytes,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             scsi_cnt_zero,
  input  logic             phase_change,
  input  logic             attention,
  input  logic             target_done,
  input  logic             beat,
  output logic             req,
  output logic             unit_two,
  output logic             cnt_nonzero
);

  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);
  localparam logic [LVL_W-1:0] BURST_L = LVL_W'(BURST_BYTES);
  localparam logic [BL_W-1:0]  BURST_B = BL_W'(BURST_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_n, cnt_after;
  logic [BL_W-1:0]  blft_q, blft_n, blft_after;
  logic             burst_q, burst_n;
  logic             drain_q, drain_n;
  logic             req_q, req_n;

  logic [LVL_W-1:0] free_bytes, unit_lvl;
  logic             unit_ok, odd_hold, odd_after, can_go;
  logic             flush_now, trig, cont;

  always_comb begin
    free_bytes = DEPTH_L - fifo_level;
    unit_two   = cfg_wide && (cnt_q >= CNT_W'(2));
    unit_lvl   = unit_two ? LVL_W'(2) : LVL_W'(1);
    unit_ok    = xfer_to_host ? (fifo_level >= unit_lvl) : (free_bytes >= unit_lvl);
    odd_hold   = cfg_wide && cfg_odd_via_fifo && (cnt_q == CNT_W'(1));
    can_go     = (cnt_q != '0) && unit_ok && !odd_hold;
    flush_now  = role_target ? (target_done || attention) : (scsi_cnt_zero || phase_change);
    trig       = xfer_to_host
                 ? (drain_q || flush_now || (!role_target && (fifo_level >= BURST_L)))
                 : (free_bytes >= BURST_L);
    cnt_after  = beat ? cnt_q - (unit_two ? CNT_W'(2) : CNT_W'(1)) : cnt_q;
    blft_after = beat ? blft_q - (unit_two ? BL_W'(2) : BL_W'(1)) : blft_q;
    odd_after  = cfg_wide && cfg_odd_via_fifo && (cnt_after == CNT_W'(1));
    cont       = 1'b0;

    cnt_n   = cnt_after;
    blft_n  = blft_q;
    burst_n = 1'b0;
    req_n   = 1'b0;
    drain_n = drain_q || flush_now;

    if (xfer_load) begin
      cnt_n   = xfer_bytes;
      blft_n  = '0;
      drain_n = 1'b0;
    end else if (!cfg_burst8) begin
      req_n  = can_go && !beat;
    end else if (burst_q) begin
      if (beat) cont = (blft_after != '0) && (cnt_after != '0) && !odd_after;
      else      cont = can_go;
      burst_n = cont;
      req_n   = cont;
      blft_n  = blft_after;
    end else if (trig && can_go) begin
      burst_n = 1'b1;
      req_n   = 1'b1;
      blft_n  = BURST_B;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      blft_q  <= '0;
      burst_q <= 1'b0;
      drain_q <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      blft_q  <= blft_n;
      burst_q <= burst_n;
      drain_q <= drain_n;
      req_q   <= req_n;
    end
  end

  assign req         = req_q;
  assign cnt_nonzero = (cnt_q != '0);

  // R2: single-transfer mode drops the request after each accepted strobe
  a_r2_drop_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_burst8 && beat) |=> !req_q);

  // R4: a write burst never starts without room for a full burst
  a_r4_write_room: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_q) && cfg_burst8 && $past(cfg_burst8) && !xfer_to_host && !$past(xfer_to_host))
      |-> $past(free_bytes >= BURST_L));

  // R4: burst budget never exceeds one burst
  a_r4_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
    blft_q <= BURST_B);

  // R7: no request while a held-back odd byte is the only one left
  a_r7_odd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && cfg_wide && cfg_odd_via_fifo && $stable(cfg_wide) && $stable(cfg_odd_via_fifo))
      |-> (cnt_q != CNT_W'(1)));

  // R11: no request with an empty count
  a_r11_no_req_empty: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (cnt_q != '0));

endmodule

// File: rtl/dma_pack.sv
module dma_pack
  import dma_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_to_host,
  input  logic        unit_two,
  input  logic        beat,
  input  logic [15:0] fifo_head,
  input  logic [15:0] dma_din,
  output logic [15:0] dma_dout,
  output logic [1:0]  dma_par,
  output logic [1:0]  fifo_pop,
  output logic [1:0]  fifo_push,
  output logic [15:0] fifo_wdata
);

  logic [1:0] unit_cnt;

  always_comb begin
    unit_cnt   = unit_two ? 2'd2 : 2'd1;
    dma_dout   = unit_two ? fifo_head : {8'hFF, fifo_head[7:0]};
    dma_par    = {odd_par(dma_dout[15:8]), odd_par(dma_dout[7:0])};
    fifo_pop   = (beat && xfer_to_host)  ? unit_cnt : 2'd0;
    fifo_push  = (beat && !xfer_to_host) ? unit_cnt : 2'd0;
    fifo_wdata = dma_din;
  end

  // R8: a single-byte read word carries ones above the data byte
  a_r8_pad_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_pop == 2'd1) |-> (dma_dout[15:8] == 8'hFF && dma_par[1]));

  // R3: at most one direction moves bytes in a cycle
  a_r3_one_way: assert property (@(posedge clk) disable iff (!rst_n)
    !((fifo_pop != 2'd0) && (fifo_push != 2'd0)));

endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
  import dma_burst_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FIFO_DEPTH  = 16,
  parameter int BURST_BYTES = 8,
  parameter int OFF_W       = 4,
  parameter int OFFS_SINGLE = 15,
  parameter int OFFS_BURST  = 7,
  localparam int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_burst8,
  input  logic             cfg_ack_hold,
  input  logic             cfg_rd_ack_pulse,
  input  logic             cfg_wide,
  input  logic             cfg_odd_via_fifo,
  input  logic             xfer_to_host,
  input  logic             role_target,
  input  logic             xfer_load,
  input  logic [CNT_W-1:0] xfer_bytes,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [15:0]      fifo_head,
  input  logic             scsi_cnt_zero,
  input  logic             phase_change,
  input  logic             attention,
  input  logic             target_done,
  input  logic             dma_ack,
  input  logic             dma_rd_stb,
  input  logic             dma_wr_stb,
  input  logic [15:0]      dma_din,
  output logic             dma_req,
  output logic [15:0]      dma_dout,
  output logic [1:0]       dma_par,
  output logic [1:0]       fifo_pop,
  output logic [1:0]       fifo_push,
  output logic [15:0]      fifo_wdata,
  output logic [OFF_W-1:0] sync_offset_max
);

  logic      beat, unit_two, cnt_nonzero;
  dma_mode_e mode;

  always_comb begin
    mode = dma_mode_e'({cfg_ack_hold, cfg_burst8});
    unique case (mode)
      MODE_BURST, MODE_HELD_ACK: sync_offset_max = OFF_W'(OFFS_BURST);
      default:                   sync_offset_max = OFF_W'(OFFS_SINGLE);
    endcase
  end

  dma_strobe_qual u_qual (
    .clk              (clk),
    .rst_n            (rst_n),
    .xfer_to_host     (xfer_to_host),
    .rd_stb           (dma_rd_stb),
    .wr_stb           (dma_wr_stb),
    .ack              (dma_ack),
    .cfg_ack_hold     (cfg_ack_hold),
    .cfg_rd_ack_pulse (cfg_rd_ack_pulse),
    .cnt_nonzero      (cnt_nonzero),
    .beat             (beat)
  );

  dma_req_ctrl #(
    .CNT_W       (CNT_W),
    .FIFO_DEPTH  (FIFO_DEPTH),
    .BURST_BYTES (BURST_BYTES)
  ) u_req (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_burst8       (cfg_burst8),
    .cfg_wide         (cfg_wide),
    .cfg_odd_via_fifo (cfg_odd_via_fifo),
    .xfer_to_host     (xfer_to_host),
    .role_target      (role_target),
    .xfer_load        (xfer_load),
    .xfer_bytes       (xfer_bytes),
    .fifo_level       (fifo_level),
    .scsi_cnt_zero    (scsi_cnt_zero),
    .phase_change     (phase_change),
    .attention        (attention),
    .target_done      (target_done),
    .beat             (beat),
    .req              (dma_req),
    .unit_two         (unit_two),
    .cnt_nonzero      (cnt_nonzero)
  );

  dma_pack u_pack (
    .clk          (clk),
    .rst_n        (rst_n),
    .xfer_to_host (xfer_to_host),
    .unit_two     (unit_two),
    .beat         (beat),
    .fifo_head    (fifo_head),
    .dma_din      (dma_din),
    .dma_dout     (dma_dout),
    .dma_par      (dma_par),
    .fifo_pop     (fifo_pop),
    .fifo_push    (fifo_push),
    .fifo_wdata   (fifo_wdata)
  );

  // R1: burst modes cap the synchronous offset
  a_r1_offset: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_burst8 |-> (sync_offset_max == OFF_W'(OFFS_BURST)));

endmodule

// File: tb/dma_burst_ctrl_tb.sv
module dma_burst_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_burst8 = 0, cfg_ack_hold = 0, cfg_rd_ack_pulse = 0;
  logic        cfg_wide = 0, cfg_odd_via_fifo = 0;
  logic        xfer_to_host = 0, role_target = 0, xfer_load = 0;
  logic [15:0] xfer_bytes = '0;
  logic [4:0]  fifo_level = '0;
  logic [15:0] fifo_head = '0;
  logic        scsi_cnt_zero = 0, phase_change = 0, attention = 0, target_done = 0;
  logic        dma_ack = 0, dma_rd_stb = 0, dma_wr_stb = 0;
  logic [15:0] dma_din = '0;
  logic        dma_req;
  logic [15:0] dma_dout, fifo_wdata;
  logic [1:0]  dma_par, fifo_pop, fifo_push;
  logic [3:0]  sync_offset_max;

  int n_checks = 0;
  int n_fail   = 0;
  logic [1:0]  s_move;
  logic [15:0] s_dout;
  logic [1:0]  s_par;

  always #4 clk = ~clk;

  dma_burst_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_burst8(cfg_burst8), .cfg_ack_hold(cfg_ack_hold),
    .cfg_rd_ack_pulse(cfg_rd_ack_pulse), .cfg_wide(cfg_wide),
    .cfg_odd_via_fifo(cfg_odd_via_fifo), .xfer_to_host(xfer_to_host),
    .role_target(role_target), .xfer_load(xfer_load), .xfer_bytes(xfer_bytes),
    .fifo_level(fifo_level), .fifo_head(fifo_head),
    .scsi_cnt_zero(scsi_cnt_zero), .phase_change(phase_change),
    .attention(attention), .target_done(target_done),
    .dma_ack(dma_ack), .dma_rd_stb(dma_rd_stb), .dma_wr_stb(dma_wr_stb),
    .dma_din(dma_din), .dma_req(dma_req), .dma_dout(dma_dout),
    .dma_par(dma_par), .fifo_pop(fifo_pop), .fifo_push(fifo_push),
    .fifo_wdata(fifo_wdata), .sync_offset_max(sync_offset_max)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic load(input int bytes);
    tick(); xfer_load = 1'b1; xfer_bytes = 16'(bytes);
    tick(); xfer_load = 1'b0;
  endtask

  // one strobe with fresh acknowledge; bench FIFO level follows the moved bytes
  task automatic strobe();
    tick();
    dma_ack = 1'b1;
    if (xfer_to_host) dma_rd_stb = 1'b1; else dma_wr_stb = 1'b1;
    #1;
    s_move = xfer_to_host ? fifo_pop : fifo_push;
    s_dout = dma_dout;
    s_par  = dma_par;
    tick();
    dma_ack = 1'b0; dma_rd_stb = 1'b0; dma_wr_stb = 1'b0;
    if (xfer_to_host) fifo_level = fifo_level - 5'(s_move);
    else              fifo_level = fifo_level + 5'(s_move);
  endtask

  task automatic t_reset();
    tick();
    check(dma_req == 1'b0, "R11 reset req", dma_req, 0);
    check(sync_offset_max == 4'd15, "R1 reset offset", sync_offset_max, 15);
  endtask

  task automatic t_offset();
    cfg_burst8 = 1; #1;
    check(sync_offset_max == 4'd7, "R1 burst offset", sync_offset_max, 7);
    cfg_ack_hold = 1; #1;
    check(sync_offset_max == 4'd7, "R1 held-ack offset", sync_offset_max, 7);
    cfg_burst8 = 0; #1;
    check(sync_offset_max == 4'd15, "R1 reserved offset", sync_offset_max, 15);
    cfg_ack_hold = 0;
  endtask

  task automatic t_single_write();
    cfg_wide = 1; xfer_to_host = 0; fifo_level = 0;
    load(5); tick();
    check(dma_req == 1'b1, "R2 req raised", dma_req, 1);
    strobe();
    check(s_move == 2'd2, "R3 word push", s_move, 2);
    check(dma_req == 1'b0, "R2 req drop after strobe", dma_req, 0);
    tick();
    check(dma_req == 1'b1, "R2 req re-raised", dma_req, 1);
    strobe(); tick(); strobe();
    check(s_move == 2'd1, "R3 odd final push", s_move, 1);
    tick();
    check(dma_req == 1'b0, "R2 req low at count end", dma_req, 0);
  endtask

  task automatic t_narrow_odd();
    cfg_wide = 0; cfg_odd_via_fifo = 1; xfer_to_host = 1;
    fifo_level = 3; fifo_head = 16'h00A5;
    load(1); tick();
    check(dma_req == 1'b1, "R9 narrow ignores odd hold", dma_req, 1);
    strobe();
    check(s_move == 2'd1, "R3 narrow pop", s_move, 1);
    check(s_dout[7:0] == 8'hA5, "R9 narrow data", s_dout[7:0], 8'hA5);
    cfg_odd_via_fifo = 0;
  endtask

  task automatic t_odd_pad();
    cfg_wide = 1; cfg_odd_via_fifo = 0; xfer_to_host = 1;
    fifo_level = 3; fifo_head = 16'h3C5A;
    load(3); tick();
    check(dma_req == 1'b1, "R2 read req", dma_req, 1);
    strobe();
    check(s_dout == 16'h3C5A, "R8 full word", s_dout, 16'h3C5A);
    check(s_par == {~^8'h3C, ~^8'h5A}, "R8 word parity", s_par, {~^8'h3C, ~^8'h5A});
    fifo_head = 16'h0077;
    tick();
    check(dma_req == 1'b1, "R8 req for last byte", dma_req, 1);
    strobe();
    check(s_move == 2'd1, "R3 last byte pop", s_move, 1);
    check(s_dout == 16'hFF77, "R8 padded word", s_dout, 16'hFF77);
    check(s_par == {1'b1, ~^8'h77}, "R8 padded parity", s_par, {1'b1, ~^8'h77});
  endtask

  task automatic t_odd_hold();
    cfg_wide = 1; cfg_odd_via_fifo = 1; xfer_to_host = 1; fifo_level = 4;
    load(3); tick();
    strobe();
    check(s_move == 2'd2, "R3 word before held byte", s_move, 2);
    tick(); tick();
    check(dma_req == 1'b0, "R7 no req for odd byte", dma_req, 0);
    cfg_odd_via_fifo = 0;
    load(0);
  endtask

  task automatic t_ack();
    cfg_wide = 1; xfer_to_host = 0; fifo_level = 0; cfg_ack_hold = 0;
    load(8); tick();
    tick(); dma_ack = 1; dma_wr_stb = 1; #1;
    check(fifo_push == 2'd2, "R10 first strobe", fifo_push, 2);
    tick(); dma_wr_stb = 0;
    tick(); dma_wr_stb = 1; #1;
    check(fifo_push == 2'd0, "R10 held ack ignored", fifo_push, 0);
    tick(); dma_wr_stb = 0; dma_ack = 0;
    tick(); dma_wr_stb = 1; #1;
    check(fifo_push == 2'd0, "R10 no ack ignored", fifo_push, 0);
    tick(); dma_wr_stb = 0;
    cfg_ack_hold = 1;
    tick(); dma_ack = 1; dma_wr_stb = 1; #1;
    check(fifo_push == 2'd2, "R10 held mode first", fifo_push, 2);
    tick(); dma_wr_stb = 0;
    tick(); dma_wr_stb = 1; #1;
    check(fifo_push == 2'd2, "R10 held mode second", fifo_push, 2);
    tick(); dma_wr_stb = 0; dma_ack = 0;
    xfer_to_host = 1; cfg_rd_ack_pulse = 1; fifo_level = 8;
    load(8);
    tick(); dma_ack = 1; dma_rd_stb = 1; #1;
    check(fifo_pop == 2'd2, "R10 read first", fifo_pop, 2);
    tick(); dma_rd_stb = 0;
    tick(); dma_rd_stb = 1; #1;
    check(fifo_pop == 2'd0, "R10 read pulse mode ignored", fifo_pop, 0);
    tick(); dma_rd_stb = 0; dma_ack = 0; cfg_rd_ack_pulse = 0;
  endtask

  task automatic t_burst_write();
    cfg_burst8 = 1; cfg_ack_hold = 1; cfg_wide = 1; xfer_to_host = 0;
    fifo_level = 9;
    load(20); tick(); tick();
    check(dma_req == 1'b0, "R4 no req with 7 free", dma_req, 0);
    fifo_level = 8; tick();
    check(dma_req == 1'b1, "R4 req with 8 free", dma_req, 1);
    for (int i = 0; i < 3; i++) begin
      strobe();
      check(dma_req == 1'b1, "R4 req held in burst", dma_req, 1);
    end
    strobe();
    check(dma_req == 1'b0, "R4 req drop at burst end", dma_req, 0);
  endtask

  task automatic t_burst_read();
    xfer_to_host = 1; role_target = 0; fifo_level = 7;
    load(20); tick(); tick();
    check(dma_req == 1'b0, "R5 no req with 7 held", dma_req, 0);
    fifo_level = 8; tick();
    check(dma_req == 1'b1, "R5 req with 8 held", dma_req, 1);
    for (int i = 0; i < 4; i++) strobe();
    check(dma_req == 1'b0, "R5 drop after burst", dma_req, 0);
    fifo_level = 3; tick(); tick();
    check(dma_req == 1'b0, "R6 no drain yet", dma_req, 0);
    phase_change = 1; tick(); phase_change = 0;
    check(dma_req == 1'b1, "R6 phase change drains", dma_req, 1);
    strobe(); tick();
    check(dma_req == 1'b0, "R6 drain stops on empty unit", dma_req, 0);
    fifo_level = 2; tick();
    check(dma_req == 1'b1, "R6 drain remembered", dma_req, 1);
  endtask

  task automatic t_target();
    role_target = 1; xfer_to_host = 1;
    load(20); fifo_level = 12; tick(); tick();
    check(dma_req == 1'b0, "R6 target ignores fill", dma_req, 0);
    attention = 1; tick(); attention = 0;
    check(dma_req == 1'b1, "R6 attention drains", dma_req, 1);
    load(20); tick();
    check(dma_req == 1'b0, "R11 load clears drain", dma_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_offset();
    t_single_write();
    t_narrow_odd();
    t_odd_pad();
    t_odd_hold();
    t_ack();
    t_burst_write();
    t_burst_read();
    t_target();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule